// File: doc/BRIEF.md
# SPI master with automatic slave-select

This block is a register-mapped SPI master for mode 0 (SCK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge). Software sets up a mode register that holds the word length, the bit order, an automatic-select enable and a clock divider. It then writes a transmit word, and the core shifts that word out while it shifts a word of the same length in. The received word goes into a single receive register with a not-empty flag and an overrun flag. Where the word lands in that register depends on the length and the bit order.

Four active-low select lines normally follow a select register that only software changes. When automatic select is on, the lines switch to the pattern held in a second register for the whole transfer, and then fall back to the software pattern.

Register map (word addresses on `reg_addr`):

| Addr | Register | Content |
|---|---|---|
| 0 | MODE | [3:0] length code, [4] LSB-first, [5] automatic select, [15:8] divider |
| 1 | EVENT | [0] not-empty, [1] overrun (write 1 to clear), [2] busy |
| 2 | TX | write starts a transfer |
| 3 | RX | received word; reading it clears not-empty |
| 4 | SEL | manual select pattern, [3:0] |
| 5 | ASEL | automatic select pattern, [3:0] |

Controller FSM states and transitions:
- ST_IDLE goes to ST_SETUP on a TX write.
- ST_SETUP lasts one cycle, with the first bit and the selects already driven, then goes to ST_LOW.
- ST_LOW goes to ST_HIGH on a divider tick. This is the rising edge and the sample point.
- ST_HIGH goes to ST_LOW on a tick while bits remain. This is the falling edge and the shift point.
- ST_HIGH goes to ST_DONE on a tick after the last bit.
- ST_DONE stores the word and goes to ST_IDLE.

Top module: `spi_asel_master`

## Requirements
- R1: After reset, SEL reads 0xF, ASEL reads 0, EVENT reads 0, `spi_ss_n` is 0xF and `spi_sck` is low.
- R2: When automatic select is off, `spi_ss_n` equals SEL at every rising SCK edge.
- R3: When automatic select (MODE bit 5) is on, `spi_ss_n` equals ASEL from ST_SETUP through the last rising SCK edge of the transfer.
- R4: When a transfer ends (busy falls), `spi_ss_n` is back to the SEL value.
- R5: The word length is N = code+1 for codes 1..15, and N = 32 for code 0. A transfer gives exactly N rising SCK edges.
- R6: MOSI carries TX bits [N-1:0]. With MODE bit 4 = 0 the order is bit N-1 first; with bit 4 = 1 the order is bit 0 first.
- R7: SCK is low whenever the core is idle. Each SCK half-period is divider+1 clock cycles. MOSI is stable across each rising SCK edge.
- R8: With code 0, RX holds the full 32-bit word, MSB at bit 31 and LSB at bit 0, in either bit order.
- R9: With a nonzero code and MSB-first order, the word's MSB sits at RX bit 15 (RX = w << (16-N)). An 8-bit all-ones word reads 0x0000FF00.
- R10: With a nonzero code and LSB-first order, the word's LSB sits at RX bit 16 (RX = w << 16). An 8-bit all-ones word reads 0x00FF0000.
- R11: EVENT bit 0 (not-empty) is set when a word is stored and is cleared by a read of RX.
- R12: If a word is stored while not-empty is already set, EVENT bit 1 (overrun) is set and RX takes the new word. Writing 1 to EVENT bit 1 clears overrun.
- R13: A TX write while busy (EVENT bit 2) is ignored. The ongoing transfer's edge count and bit stream do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on RX) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 4 | Active-low slave selects |

## Verification
The two hardest situations to reach from the ports are the handover of the select lines at both ends of a transfer, and the overrun case where a second word arrives before the first has been read. The bench loops MOSI back to MISO, with an optional inversion. It sweeps every length code in both bit orders, alternates automatic and manual select with different patterns, and compares the select lines at each rising SCK edge and again right after busy drops. It reaches overrun on purpose by running two transfers back to back without reading RX. It reaches the ignored-write case by writing TX again in the middle of a slow transfer.

// File: rtl/spi_asel_pkg.sv
package spi_asel_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 4;
    localparam int CNT_W  = 6;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVENT = 3'd1;
    localparam logic [ADDR_W-1:0] A_TX    = 3'd2;
    localparam logic [ADDR_W-1:0] A_RX    = 3'd3;
    localparam logic [ADDR_W-1:0] A_SEL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_ASEL  = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } xfer_state_t;

    // Word length in bits for a length code: code+1, code 0 is a full word
    function automatic logic [CNT_W-1:0] word_bits(input logic [LEN_W-1:0] code);
        if (code == '0)
            return CNT_W'(WORD_W);
        return CNT_W'(code) + CNT_W'(1);
    endfunction
endpackage

// File: rtl/spi_asel_clkdiv.sv
module spi_asel_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == div)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_asel_engine.sv
module spi_asel_engine
    import spi_asel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              rev,
    input  logic              auto_en,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              run,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic              auto_q,
    output logic              rev_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [CNT_W-1:0]  bits_q,
    output logic [WORD_W-1:0] rx_raw
);
    xfer_state_t       state_q, state_d;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  start_bits;
    logic [CNT_W-1:0]  align_sh;

    assign start_bits = word_bits(len);
    assign align_sh   = CNT_W'(WORD_W) - start_bits;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = (left_q == CNT_W'(1)) ? ST_DONE : ST_LOW;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy = 1'b1;
        run  = 1'b0;
        sck  = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: ;
            ST_LOW:   run = 1'b1;
            ST_HIGH:  begin run = 1'b1; sck = 1'b1; end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign mosi   = rev_q ? tx_sh_q[0] : tx_sh_q[WORD_W-1];
    assign rx_raw = rx_sh_q;

    // datapath: configuration latch, shift registers, bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q  <= 1'b0;
            rev_q   <= 1'b0;
            len_q   <= '0;
            bits_q  <= '0;
            left_q  <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                auto_q  <= auto_en;
                rev_q   <= rev;
                len_q   <= len;
                bits_q  <= start_bits;
                left_q  <= start_bits;
                tx_sh_q <= rev ? tx_word : (tx_word << align_sh);
                rx_sh_q <= '0;
            end
            if (state_q == ST_LOW && tick)
                rx_sh_q <= rev_q ? {miso, rx_sh_q[WORD_W-1:1]}
                                 : {rx_sh_q[WORD_W-2:0], miso};
            if (state_q == ST_HIGH && tick) begin
                left_q  <= left_q - 1'b1;
                tx_sh_q <= rev_q ? (tx_sh_q >> 1) : (tx_sh_q << 1);
            end
        end
    end
endmodule

// File: rtl/spi_asel_rxalign.sv
module spi_asel_rxalign
    import spi_asel_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic [LEN_W-1:0]  len,
    input  logic              rev,
    output logic [WORD_W-1:0] placed
);
    localparam int HALF = WORD_W / 2;
    logic [CNT_W-1:0] n;
    logic [CNT_W-1:0] gap;

    assign n   = word_bits(len);
    assign gap = CNT_W'(HALF) - n;

    always_comb begin
        if (len == '0)
            placed = raw;
        else if (rev)
            placed = raw >> gap;   // word sits in top bits; LSB lands on bit HALF
        else
            placed = raw << gap;   // word sits in low bits; MSB lands on bit HALF-1
    end
endmodule

// File: rtl/spi_asel_master.sv
module spi_asel_master
    import spi_asel_pkg::*;
#(
    parameter int SS_W  = 4,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [SS_W-1:0]   spi_ss_n
);
    localparam int DIV_LSB = 8;

    logic [LEN_W-1:0]  len_cfg;
    logic              rev_cfg;
    logic              auto_cfg;
    logic [DIV_W-1:0]  div_cfg;
    logic [SS_W-1:0]   slvsel_q;
    logic [SS_W-1:0]   aslvsel_q;
    logic [WORD_W-1:0] rx_q;
    logic              ne_q;
    logic              ovr_q;

    logic              busy, run, tick, done, auto_q, rev_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  bits_q;
    logic [WORD_W-1:0] rx_raw, rx_placed;
    logic              start, rx_rd;

    assign start = reg_wr && reg_addr == A_TX && !busy;
    assign rx_rd = reg_rd && reg_addr == A_RX;

    spi_asel_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_cfg), .tick(tick)
    );

    spi_asel_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(reg_wdata),
        .len(len_cfg), .rev(rev_cfg), .auto_en(auto_cfg), .tick(tick),
        .miso(spi_miso), .busy(busy), .run(run), .sck(spi_sck),
        .mosi(spi_mosi), .done(done), .auto_q(auto_q), .rev_q(rev_q),
        .len_q(len_q), .bits_q(bits_q), .rx_raw(rx_raw)
    );

    spi_asel_rxalign u_align (
        .raw(rx_raw), .len(len_q), .rev(rev_q), .placed(rx_placed)
    );

    // configuration and select registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_cfg   <= '0;
            rev_cfg   <= 1'b0;
            auto_cfg  <= 1'b0;
            div_cfg   <= '0;
            slvsel_q  <= '1;
            aslvsel_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_MODE: begin
                    len_cfg  <= reg_wdata[LEN_W-1:0];
                    rev_cfg  <= reg_wdata[4];
                    auto_cfg <= reg_wdata[5];
                    div_cfg  <= reg_wdata[DIV_LSB +: DIV_W];
                end
                A_SEL:   slvsel_q  <= reg_wdata[SS_W-1:0];
                A_ASEL:  aslvsel_q <= reg_wdata[SS_W-1:0];
                default: ;
            endcase
        end
    end

    // receive holding register and event flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            ne_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (done) begin
                rx_q <= rx_placed;
                ne_q <= 1'b1;
                if (ne_q && !rx_rd)
                    ovr_q <= 1'b1;
            end else if (rx_rd) begin
                ne_q <= 1'b0;
            end
            if (reg_wr && reg_addr == A_EVENT && reg_wdata[1] && !done)
                ovr_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_MODE: begin
                reg_rdata[LEN_W-1:0]         = len_cfg;
                reg_rdata[4]                 = rev_cfg;
                reg_rdata[5]                 = auto_cfg;
                reg_rdata[DIV_LSB +: DIV_W]  = div_cfg;
            end
            A_EVENT: reg_rdata[2:0]      = {busy, ovr_q, ne_q};
            A_RX:    reg_rdata           = rx_q;
            A_SEL:   reg_rdata[SS_W-1:0] = slvsel_q;
            A_ASEL:  reg_rdata[SS_W-1:0] = aslvsel_q;
            default: reg_rdata           = '0;
        endcase
    end

    assign spi_ss_n = (busy && auto_q) ? aslvsel_q : slvsel_q;
endmodule

// File: rtl/spi_asel_checker.sv
module spi_asel_checker
    import spi_asel_pkg::*;
#(
    parameter int SS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sck,
    input logic             mosi,
    input logic [SS_W-1:0]  ss_n,
    input logic [SS_W-1:0]  slvsel,
    input logic [SS_W-1:0]  aslvsel,
    input logic             auto_q,
    input logic             ne,
    input logic             ovr,
    input logic             done,
    input logic             rx_rd,
    input logic [CNT_W-1:0] bits
);
    logic             sck_d;
    logic [CNT_W:0]   edge_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            sck_d <= sck;
            if (!busy)
                edge_cnt <= '0;
            else if (sck && !sck_d)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    p_idle_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !sck_d) |-> $stable(mosi));
    p_manual_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !sck_d && !auto_q) |-> ss_n == slvsel);
    p_auto_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !sck_d && auto_q) |-> ss_n == aslvsel);
    p_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ss_n == slvsel);
    p_edge_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> edge_cnt == {1'b0, bits});
    p_ne_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ne);
    p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !done) |=> !ne);
    p_ovr_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(ne));
endmodule

bind spi_asel_master spi_asel_checker #(.SS_W(SS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
    .ss_n(spi_ss_n), .slvsel(slvsel_q), .aslvsel(aslvsel_q), .auto_q(auto_q),
    .ne(ne_q), .ovr(ovr_q), .done(done), .rx_rd(rx_rd), .bits(bits_q)
);

// File: tb/tb_spi_asel_master.sv
`timescale 1ns/1ps
module tb_spi_asel_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_ss_n;
    logic        miso_inv = 1'b0;

    int checks = 0, errors = 0;
    logic [63:0] mon_bits;
    int          mon_cnt;
    int          ss_bad;
    logic [3:0]  exp_ss;
    longint      t_rise, high_t;
    logic        finished = 1'b0;

    always #2 clk = ~clk;
    assign spi_miso = spi_mosi ^ miso_inv;

    spi_asel_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n)
    );

    always @(posedge spi_sck) begin
        mon_bits = {mon_bits[62:0], spi_mosi};
        mon_cnt  = mon_cnt + 1;
        if (spi_ss_n !== exp_ss) ss_bad = ss_bad + 1;
        t_rise = $time;
    end
    always @(negedge spi_sck) high_t = $time - t_rise;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] ev;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd1, ev);
            if (!ev[2]) return;
        end
        chk("R5 transfer completes", 64'd0, 64'd1);
    endtask

    function automatic int nbits(input int code);
        return (code == 0) ? 32 : code + 1;
    endfunction

    function automatic logic [63:0] exp_stream(input logic [31:0] tx, input int n, input bit rev);
        logic [63:0] s = '0;
        for (int i = 0; i < n; i++)
            s = {s[62:0], rev ? tx[i] : tx[n-1-i]};
        return s;
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] tx, input int code, input bit rev, input bit inv);
        int n = nbits(code);
        logic [31:0] w = inv ? ~tx : tx;
        if (n < 32) w = w & ((32'd1 << n) - 32'd1);
        if (code == 0) return w;
        if (rev) return w << 16;
        return w << (16 - n);
    endfunction

    task automatic xfer(input int code, input bit rev, input bit aut, input int div,
                        input logic [31:0] tx, input bit inv,
                        input logic [3:0] sel, input logic [3:0] asel);
        logic [31:0] d;
        int n = nbits(code);
        wr(3'd4, {28'd0, sel});
        wr(3'd5, {28'd0, asel});
        wr(3'd0, {16'd0, 8'(div), 2'b00, aut, rev, 4'(code)});
        miso_inv = inv;
        exp_ss = aut ? asel : sel;
        mon_bits = '0; mon_cnt = 0; ss_bad = 0;
        wr(3'd2, tx);
        wait_idle();
        chk("R5 rising edge count", 64'(mon_cnt), 64'(n));
        chk("R6 MOSI bit stream", mon_bits, exp_stream(tx, n, rev));
        chk(aut ? "R3 auto select at edges" : "R2 manual select at edges", 64'(ss_bad), 64'd0);
        chk("R4 select restored", 64'(spi_ss_n), 64'(sel));
        chk("R7 high half period", 64'(high_t), 64'((div + 1) * 4));
        chk("R7 sck idle low", 64'(spi_sck), 64'd0);
        rd(3'd1, d);
        chk("R11 not-empty set", 64'(d[0]), 64'd1);
        rd(3'd3, d);
        chk(code == 0 ? "R8 full word" : (rev ? "R10 LSB at bit 16" : "R9 MSB at bit 15"),
            64'(d), 64'(exp_rx(tx, code, rev, inv)));
        rd(3'd1, d);
        chk("R11 read clears not-empty", 64'(d[0]), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        exp_ss = 4'hF;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ss_n reset", 64'(spi_ss_n), 64'hF);
        chk("R1 sck reset", 64'(spi_sck), 64'd0);
        rst_n = 1'b1;
        rd(3'd4, d); chk("R1 SEL reset", 64'(d), 64'hF);
        rd(3'd5, d); chk("R1 ASEL reset", 64'(d), 64'h0);
        rd(3'd1, d); chk("R1 EVENT reset", 64'(d), 64'h0);

        // placement examples: 8 ones
        xfer(7, 1'b0, 1'b0, 0, 32'h0000_00FF, 1'b0, 4'hE, 4'h0);
        xfer(7, 1'b1, 1'b1, 0, 32'h0000_00FF, 1'b0, 4'hE, 4'h7);

        // sweep of every length code and both orders
        for (int code = 0; code < 16; code++) begin
            for (int r = 0; r < 2; r++) begin
                logic [31:0] tx = 32'hA5C3_96E1 ^ (32'h1111_1111 * code) ^ (r ? 32'h0F0F_3C3C : 32'h0);
                xfer(code, r[0], code[0] ^ r[0], code % 3, tx, r[0] ^ code[1],
                     4'hF ^ (4'd1 << (code % 4)), 4'(code) ^ 4'h5);
            end
        end

        // R12 overrun: two words without reading RX
        wr(3'd0, {16'd0, 8'd0, 2'b00, 1'b0, 1'b0, 4'd3});
        miso_inv = 1'b0;
        wr(3'd2, 32'h9); wait_idle();
        wr(3'd2, 32'h6); wait_idle();
        rd(3'd1, d); chk("R12 overrun and not-empty", 64'(d[2:0]), 64'h3);
        rd(3'd3, d); chk("R12 newest word kept", 64'(d), 64'h6000);
        rd(3'd1, d); chk("R12 overrun survives read", 64'(d[2:0]), 64'h2);
        wr(3'd1, 32'h2);
        rd(3'd1, d); chk("R12 overrun cleared", 64'(d[2:0]), 64'h0);

        // R13 write while busy is ignored
        wr(3'd4, 32'hB);
        exp_ss = 4'hB;
        wr(3'd0, {16'd0, 8'd2, 2'b00, 1'b0, 1'b0, 4'd7});
        mon_bits = '0; mon_cnt = 0; ss_bad = 0;
        wr(3'd2, 32'h5A);
        repeat (8) @(negedge clk);
        wr(3'd2, 32'hFF);
        wait_idle();
        chk("R13 edge count unchanged", 64'(mon_cnt), 64'd8);
        chk("R13 stream of first word", mon_bits, exp_stream(32'h5A, 8, 1'b0));
        rd(3'd3, d); chk("R13 received first word", 64'(d), 64'h5A00);
        rd(3'd1, d); chk("R13 no second transfer", 64'(d[2:0]), 64'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule